// File: doc/BRIEF.md
# Page-One Stack Sequencer

This block carries out the memory traffic an 8-bit processor core needs whenever it touches its hardware stack. The stack lives in one fixed 256-byte page, and the byte address of any stack slot is the page number concatenated with the stack pointer. The core hands over a single command along with its current program counter, accumulator, status byte and stack pointer. The sequencer then runs the one to five byte accesses that the command needs over a single-port synchronous memory. When it finishes, it returns the updated program counter, stack pointer, accumulator and status byte, and it marks completion with a one-cycle `done` pulse.

Eight commands are supported. Two push a register (the accumulator or the status byte). Two pull a register. A subroutine call pushes a return address and loads a target. A subroutine return pulls that address back. A software break pushes a return address and the status byte, then loads a new program counter from a fixed two-byte vector. A return from interrupt restores the status byte and then the program counter. The sequencer fixes the exact byte order, the plus-one and minus-one adjustments on saved addresses, and the handling of status bits 5 and 4.

The memory port is block-RAM shaped. Enable, write strobe, address and write data are registered outputs. Read data comes back on `mem_rdata` in the cycle after the access. All command fields are latched when the command is accepted.

Top module: `stk_seq`

## Requirements
- R1: Every stack access uses address {STACK_PAGE, x}, where x is an 8-bit index that wraps modulo 256. A push writes at index S and later pushes go to S-1, S-2. A pull reads first at S+1 and then at S+2 and S+3. Every write targets the stack page. The only accesses outside the page are the two break-vector reads.
- R2: Command code 0 writes `acc_in` at S. Command code 1 writes `flags_in` with bit 4 forced to 1 at S. Both return S-1, and all other outputs equal the latched inputs.
- R3: Command code 2 reads byte v at S+1 and returns acc = v. Status bit 7 becomes v[7], bit 1 becomes (v == 0), and the other status bits are unchanged. It returns S+1.
- R4: Command code 3 reads byte v at S+1 and returns status = (v & 0xCF) | (flags_in & 0x30). It returns S+1.
- R5: Command code 4 (call) writes the high byte of `pc_in`-1 at S, then the low byte at S-1. It returns pc = `call_tgt` and S-2.
- R6: Command code 5 (return) reads the low byte at S+1 and the high byte at S+2. It returns pc = {high, low}+1 and S+2.
- R7: Command code 6 (break) writes the high byte of `pc_in`+1 at S, the low byte at S-1, and `flags_in`|0x10 at S-2. It then reads BRK_VECTOR (low byte) and BRK_VECTOR+1 (high byte). It returns pc = {high, low}, status = `flags_in`|0x14 and S-3. The vector addresses are never written.
- R8: Command code 7 (return from interrupt) reads the status byte v at S+1, the low PC byte at S+2 and the high byte at S+3. It returns status = (v & 0xCF) | (flags_in & 0x30), pc = {high, low} with no increment, and S+3.
- R9: The N accesses of a command occupy the N consecutive cycles after the accepting clock edge. Results appear on the outputs together with a one-cycle `done` pulse that is high in the second cycle after the last access cycle. That is N+2 rising edges counting the accepting one.
- R10: A command is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until `done` rises. `cmd_valid` while busy is ignored. No memory access happens while not busy.
- R11: After synchronous reset, all result outputs are zero and `busy`, `done` and `mem_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_op | input | 3 | Command code 0..7 (see R2-R8) |
| pc_in | input | 16 | Current program counter (address after the instruction) |
| call_tgt | input | 16 | Destination loaded by a call |
| acc_in | input | 8 | Current accumulator |
| flags_in | input | 8 | Current status byte |
| sp_in | input | 8 | Current stack pointer |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read access |
| pc_out | output | 16 | Resulting program counter |
| sp_out | output | 8 | Resulting stack pointer |
| acc_out | output | 8 | Resulting accumulator |
| flags_out | output | 8 | Resulting status byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse, results valid |

## Verification
The bench builds the block with its default parameters: stack page 0x01 and break vector 0xFFFE. With that small configuration it sweeps every command code against all 256 stack pointer values. This covers every wrap of the index across 0x00/0xFF for pushes and pulls, and every borrow or carry out of the low PC byte when saving call and break addresses. Directed cases add pulled bytes of 0x00, 0x7F and 0x80, complementary status masks, and a command request held high during a busy sequence.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int RD_SLOTS = 3;
  localparam int MAX_ACC  = 5;
  localparam int IDX_W    = $clog2(MAX_ACC + 1);
  localparam int CNT_W    = $clog2(RD_SLOTS + 1);

  localparam logic [DATA_W-1:0] FLG_NEG   = 8'h80;
  localparam logic [DATA_W-1:0] FLG_BRK   = 8'h10;
  localparam logic [DATA_W-1:0] FLG_IRQ   = 8'h04;
  localparam logic [DATA_W-1:0] FLG_ZERO  = 8'h02;
  localparam logic [DATA_W-1:0] PULL_MASK = 8'hCF;

  typedef enum logic [2:0] {
    OP_PUSH_ACC = 3'd0,
    OP_PUSH_FLG = 3'd1,
    OP_PULL_ACC = 3'd2,
    OP_PULL_FLG = 3'd3,
    OP_CALL     = 3'd4,
    OP_RET      = 3'd5,
    OP_BRK      = 3'd6,
    OP_RTI      = 3'd7
  } stk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_TAIL = 2'd2
  } stk_state_e;
endpackage

// File: rtl/stk_access_gen.sv
module stk_access_gen
  import stk_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] BRK_VECTOR = 16'hFFFE
) (
  input  stk_op_e            op,
  input  logic [IDX_W-1:0]   idx,
  input  logic [DATA_W-1:0]  sp,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [DATA_W-1:0]  acc,
  input  logic [DATA_W-1:0]  flags,
  output logic [ADDR_W-1:0]  addr,
  output logic               we,
  output logic [DATA_W-1:0]  wdata,
  output logic               last
);
  logic [DATA_W-1:0] down_idx, up_idx;
  logic [ADDR_W-1:0] call_ret, brk_ret;

  // pushes walk downward from S, pulls walk upward from S+1
  assign down_idx = sp - DATA_W'(idx);
  assign up_idx   = sp + DATA_W'(1) + DATA_W'(idx);
  assign call_ret = pc - ADDR_W'(1);
  assign brk_ret  = pc + ADDR_W'(1);

  always_comb begin
    addr  = {STACK_PAGE, down_idx};
    we    = 1'b0;
    wdata = '0;
    last  = 1'b0;
    case (op)
      OP_PUSH_ACC: begin
        we = 1'b1; wdata = acc; last = 1'b1;
      end
      OP_PUSH_FLG: begin
        we = 1'b1; wdata = flags | FLG_BRK; last = 1'b1;
      end
      OP_PULL_ACC, OP_PULL_FLG: begin
        addr = {STACK_PAGE, up_idx}; last = 1'b1;
      end
      OP_CALL: begin
        we    = 1'b1;
        wdata = (idx == '0) ? call_ret[15:8] : call_ret[7:0];
        last  = (idx == IDX_W'(1));
      end
      OP_RET: begin
        addr = {STACK_PAGE, up_idx};
        last = (idx == IDX_W'(1));
      end
      OP_BRK: begin
        case (idx)
          IDX_W'(0): begin we = 1'b1; wdata = brk_ret[15:8]; end
          IDX_W'(1): begin we = 1'b1; wdata = brk_ret[7:0]; end
          IDX_W'(2): begin we = 1'b1; wdata = flags | FLG_BRK; end
          IDX_W'(3): addr = BRK_VECTOR;
          default: begin
            addr = BRK_VECTOR + ADDR_W'(1);
            last = 1'b1;
          end
        endcase
      end
      default: begin  // OP_RTI
        addr = {STACK_PAGE, up_idx};
        last = (idx == IDX_W'(2));
      end
    endcase
  end
endmodule

// File: rtl/stk_result.sv
module stk_result
  import stk_pkg::*;
(
  input  stk_op_e                          op,
  input  logic [ADDR_W-1:0]                pc,
  input  logic [ADDR_W-1:0]                tgt,
  input  logic [DATA_W-1:0]                acc,
  input  logic [DATA_W-1:0]                flags,
  input  logic [DATA_W-1:0]                sp,
  input  logic [RD_SLOTS-1:0][DATA_W-1:0]  rd,
  output logic [ADDR_W-1:0]                pc_n,
  output logic [DATA_W-1:0]                sp_n,
  output logic [DATA_W-1:0]                acc_n,
  output logic [DATA_W-1:0]                flg_n
);
  logic [DATA_W-1:0] pulled_flags;
  logic [DATA_W-1:0] acc_flags;

  // bits 5 and 4 never come from memory
  assign pulled_flags = (rd[0] & PULL_MASK) | (flags & ~PULL_MASK);
  assign acc_flags    = (flags & ~(FLG_NEG | FLG_ZERO))
                      | (rd[0] & FLG_NEG)
                      | ((rd[0] == '0) ? FLG_ZERO : '0);

  always_comb begin
    pc_n  = pc;
    sp_n  = sp;
    acc_n = acc;
    flg_n = flags;
    case (op)
      OP_PUSH_ACC, OP_PUSH_FLG: sp_n = sp - DATA_W'(1);
      OP_PULL_ACC: begin
        acc_n = rd[0];
        flg_n = acc_flags;
        sp_n  = sp + DATA_W'(1);
      end
      OP_PULL_FLG: begin
        flg_n = pulled_flags;
        sp_n  = sp + DATA_W'(1);
      end
      OP_CALL: begin
        pc_n = tgt;
        sp_n = sp - DATA_W'(2);
      end
      OP_RET: begin
        pc_n = {rd[1], rd[0]} + ADDR_W'(1);
        sp_n = sp + DATA_W'(2);
      end
      OP_BRK: begin
        pc_n  = {rd[1], rd[0]};
        flg_n = flags | FLG_BRK | FLG_IRQ;
        sp_n  = sp - DATA_W'(3);
      end
      default: begin  // OP_RTI
        flg_n = pulled_flags;
        pc_n  = {rd[2], rd[1]};
        sp_n  = sp + DATA_W'(3);
      end
    endcase
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] BRK_VECTOR = 16'hFFFE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [ADDR_W-1:0]  pc_in,
  input  logic [ADDR_W-1:0]  call_tgt,
  input  logic [DATA_W-1:0]  acc_in,
  input  logic [DATA_W-1:0]  flags_in,
  input  logic [DATA_W-1:0]  sp_in,
  output logic               mem_en,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [ADDR_W-1:0]  pc_out,
  output logic [DATA_W-1:0]  sp_out,
  output logic [DATA_W-1:0]  acc_out,
  output logic [DATA_W-1:0]  flags_out,
  output logic               busy,
  output logic               done
);
  stk_state_e        state_q;
  stk_op_e           op_q;
  logic [ADDR_W-1:0] pc_q, tgt_q;
  logic [DATA_W-1:0] acc_q, flg_q, sp_q;
  logic [IDX_W-1:0]  idx_q;
  logic              last_q;
  logic              rdv_q;
  logic [CNT_W-1:0]  rd_cnt_q;

  logic [RD_SLOTS-1:0][DATA_W-1:0] slot_q, slot_d;

  // access generator sees the live command while idle, latched copy after
  logic              take;
  stk_op_e           g_op;
  logic [IDX_W-1:0]  g_idx;
  logic [DATA_W-1:0] g_sp, g_acc, g_flg;
  logic [ADDR_W-1:0] g_pc;
  logic [ADDR_W-1:0] g_addr;
  logic              g_we, g_last;
  logic [DATA_W-1:0] g_wdata;

  assign take  = (state_q == ST_IDLE);
  assign g_op  = take ? stk_op_e'(cmd_op) : op_q;
  assign g_idx = take ? '0 : idx_q;
  assign g_sp  = take ? sp_in : sp_q;
  assign g_acc = take ? acc_in : acc_q;
  assign g_flg = take ? flags_in : flg_q;
  assign g_pc  = take ? pc_in : pc_q;

  stk_access_gen #(
    .STACK_PAGE (STACK_PAGE),
    .BRK_VECTOR (BRK_VECTOR)
  ) u_gen (
    .op    (g_op),
    .idx   (g_idx),
    .sp    (g_sp),
    .pc    (g_pc),
    .acc   (g_acc),
    .flags (g_flg),
    .addr  (g_addr),
    .we    (g_we),
    .wdata (g_wdata),
    .last  (g_last)
  );

  // read-data slots, filled in the order reads return
  for (genvar g = 0; g < RD_SLOTS; g++) begin : g_slot
    assign slot_d[g] = (rdv_q && rd_cnt_q == CNT_W'(g)) ? mem_rdata : slot_q[g];
    always_ff @(posedge clk) begin
      if (rst) slot_q[g] <= '0;
      else     slot_q[g] <= slot_d[g];
    end
  end

  logic [ADDR_W-1:0] r_pc;
  logic [DATA_W-1:0] r_sp, r_acc, r_flg;

  stk_result u_res (
    .op    (op_q),
    .pc    (pc_q),
    .tgt   (tgt_q),
    .acc   (acc_q),
    .flags (flg_q),
    .sp    (sp_q),
    .rd    (slot_d),
    .pc_n  (r_pc),
    .sp_n  (r_sp),
    .acc_n (r_acc),
    .flg_n (r_flg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_PUSH_ACC;
      pc_q      <= '0;
      tgt_q     <= '0;
      acc_q     <= '0;
      flg_q     <= '0;
      sp_q      <= '0;
      idx_q     <= '0;
      last_q    <= 1'b0;
      rdv_q     <= 1'b0;
      rd_cnt_q  <= '0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      pc_out    <= '0;
      sp_out    <= '0;
      acc_out   <= '0;
      flags_out <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done  <= 1'b0;
      rdv_q <= mem_en & ~mem_we;
      if (rdv_q) rd_cnt_q <= rd_cnt_q + CNT_W'(1);
      case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q      <= stk_op_e'(cmd_op);
            pc_q      <= pc_in;
            tgt_q     <= call_tgt;
            acc_q     <= acc_in;
            flg_q     <= flags_in;
            sp_q      <= sp_in;
            mem_en    <= 1'b1;
            mem_we    <= g_we;
            mem_addr  <= g_addr;
            mem_wdata <= g_wdata;
            last_q    <= g_last;
            idx_q     <= IDX_W'(1);
            rd_cnt_q  <= '0;
            busy      <= 1'b1;
            state_q   <= ST_ACC;
          end
        end
        ST_ACC: begin
          if (last_q) begin
            mem_en  <= 1'b0;
            mem_we  <= 1'b0;
            state_q <= ST_TAIL;
          end else begin
            mem_we    <= g_we;
            mem_addr  <= g_addr;
            mem_wdata <= g_wdata;
            last_q    <= g_last;
            idx_q     <= idx_q + IDX_W'(1);
          end
        end
        default: begin  // ST_TAIL: last read byte arrives here
          pc_out    <= r_pc;
          sp_out    <= r_sp;
          acc_out   <= r_acc;
          flags_out <= r_flg;
          done      <= 1'b1;
          busy      <= 1'b0;
          state_q   <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/stk_seq_checker.sv
module stk_seq_checker #(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] BRK_VECTOR = 16'hFFFE
) (
  input logic        clk,
  input logic        rst,
  input logic        cmd_valid,
  input logic        busy,
  input logic        done,
  input logic        mem_en,
  input logic        mem_we,
  input logic [15:0] mem_addr
);
  assert_in_region_R1: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> (mem_addr[15:8] == STACK_PAGE) || (mem_addr == BRK_VECTOR)
               || (mem_addr == BRK_VECTOR + 16'd1));

  assert_write_in_page_R1: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |-> (mem_addr[15:8] == STACK_PAGE));

  assert_vector_read_only_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_en && (mem_addr == BRK_VECTOR || mem_addr == BRK_VECTOR + 16'd1)) |-> !mem_we);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_from_request_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid));

  assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> busy);
endmodule

bind stk_seq stk_seq_checker #(
  .STACK_PAGE (STACK_PAGE),
  .BRK_VECTOR (BRK_VECTOR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .busy      (busy),
  .done      (done),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr)
);

// File: tb/stk_seq_test.sv
module stk_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [15:0] pc_in = '0, call_tgt = '0;
  logic [7:0]  acc_in = '0, flags_in = '0, sp_in = '0;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] pc_out;
  logic [7:0]  sp_out, acc_out, flags_out;
  logic        busy, done;

  stk_seq uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .pc_in(pc_in), .call_tgt(call_tgt), .acc_in(acc_in), .flags_in(flags_in),
    .sp_in(sp_in), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_out(pc_out),
    .sp_out(sp_out), .acc_out(acc_out), .flags_out(flags_out),
    .busy(busy), .done(done)
  );

  // memory model: bench owns page/vector contents, model logs writes
  logic [7:0]  page [0:255];
  logic [7:0]  vlo = '0, vhi = '0;
  logic [15:0] wlog_a [0:7];
  logic [7:0]  wlog_d [0:7];
  logic [31:0] wcount = '0;
  int          stray = 0;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        if (mem_addr[15:8] != 8'h01) stray <= stray + 1;
        wlog_a[wcount[2:0]] <= mem_addr;
        wlog_d[wcount[2:0]] <= mem_wdata;
        wcount <= wcount + 1;
      end else if (mem_addr[15:8] == 8'h01) mem_rdata <= page[mem_addr[7:0]];
      else if (mem_addr == 16'hFFFE) mem_rdata <= vlo;
      else if (mem_addr == 16'hFFFF) mem_rdata <= vhi;
      else begin
        mem_rdata <= 8'h00;
        stray <= stray + 1;
      end
    end
  end

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run_case(input logic [2:0] op, input logic [7:0] s,
                          input logic [15:0] pc, input logic [15:0] tgt,
                          input logic [7:0] a, input logic [7:0] f,
                          input bit frc, input logic [7:0] fval, input bit poke);
    logic [15:0] epc, r;
    logic [7:0]  esp, eacc, eflg, v;
    logic [15:0] ea [0:2];
    logic [7:0]  ed [0:2];
    int en, nacc, cyc;
    logic [31:0] w0;
    string rq;
    rq = req_of(op);
    for (int i = 0; i < 256; i++) page[i] = 8'(i * 29 + s * 3 + op * 71 + 11);
    if (frc) page[8'(s + 8'd1)] = fval;
    vlo = s ^ 8'h5A;
    vhi = 8'(op * 16 + 7) ^ ~s;
    epc = pc; esp = s; eacc = a; eflg = f; en = 0;
    for (int k = 0; k < 3; k++) begin ea[k] = '0; ed[k] = '0; end
    case (op)
      3'd0: begin nacc = 1; en = 1; ea[0] = {8'h01, s}; ed[0] = a; esp = s - 8'd1; end
      3'd1: begin nacc = 1; en = 1; ea[0] = {8'h01, s}; ed[0] = f | 8'h10; esp = s - 8'd1; end
      3'd2: begin
        nacc = 1; v = page[8'(s + 8'd1)]; eacc = v;
        eflg = (f & 8'h7D) | (v & 8'h80) | ((v == 8'h00) ? 8'h02 : 8'h00);
        esp = s + 8'd1;
      end
      3'd3: begin
        nacc = 1; v = page[8'(s + 8'd1)];
        eflg = (v & 8'hCF) | (f & 8'h30); esp = s + 8'd1;
      end
      3'd4: begin
        nacc = 2; r = pc - 16'd1; en = 2;
        ea[0] = {8'h01, s}; ed[0] = r[15:8];
        ea[1] = {8'h01, 8'(s - 8'd1)}; ed[1] = r[7:0];
        epc = tgt; esp = s - 8'd2;
      end
      3'd5: begin
        nacc = 2; epc = {page[8'(s + 8'd2)], page[8'(s + 8'd1)]} + 16'd1;
        esp = s + 8'd2;
      end
      3'd6: begin
        nacc = 5; r = pc + 16'd1; en = 3;
        ea[0] = {8'h01, s}; ed[0] = r[15:8];
        ea[1] = {8'h01, 8'(s - 8'd1)}; ed[1] = r[7:0];
        ea[2] = {8'h01, 8'(s - 8'd2)}; ed[2] = f | 8'h10;
        epc = {vhi, vlo}; eflg = f | 8'h14; esp = s - 8'd3;
      end
      default: begin
        nacc = 3; v = page[8'(s + 8'd1)];
        eflg = (v & 8'hCF) | (f & 8'h30);
        epc = {page[8'(s + 8'd3)], page[8'(s + 8'd2)]};
        esp = s + 8'd3;
      end
    endcase

    @(negedge clk);
    cmd_op = op; sp_in = s; pc_in = pc; call_tgt = tgt; acc_in = a; flags_in = f;
    cmd_valid = 1'b1;
    w0 = wcount;
    @(negedge clk);
    cyc = 1;
    if (poke) begin
      cmd_op = op ^ 3'd5; sp_in = ~s; acc_in = ~a; flags_in = ~f; pc_in = ~pc;
    end else cmd_valid = 1'b0;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (cyc == 3) cmd_valid = 1'b0;
    end
    cmd_valid = 1'b0;
    chk("R9", "cycles to done", cyc, nacc + 2);
    chk(rq, "pc_out", pc_out, epc);
    chk(rq, "sp_out", sp_out, esp);
    chk(rq, "acc_out", acc_out, eacc);
    chk(rq, "flags_out", flags_out, eflg);
    chk(poke ? "R10" : rq, "write count", wcount - w0, en);
    for (int k = 0; k < en; k++) begin
      chk("R1", "write addr", wlog_a[3'(w0 + k)], ea[k]);
      chk(rq, "write data", wlog_d[3'(w0 + k)], ed[k]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk("R11", "pc_out", pc_out, 0);
    chk("R11", "sp_out", sp_out, 0);
    chk("R11", "acc/flags", {acc_out, flags_out}, 0);
    chk("R11", "busy/done/mem_en", {busy, done, mem_en}, 0);

    // sweep: every command at every stack pointer (covers R1 wrap)
    for (int op = 0; op < 8; op++) begin
      for (int s = 0; s < 256; s++) begin
        run_case(3'(op), 8'(s), {8'(s) ^ 8'h3C, ~8'(s)}, {~8'(s), 8'(s) ^ 8'h99},
                 8'(s * 7 + op), 8'(s) ^ 8'hA5 ^ 8'(op), 1'b0, 8'h00, 1'b0);
      end
    end

    // R3 directed pulled values
    run_case(3'd2, 8'h10, 16'h1234, 16'h0, 8'h55, 8'h00, 1'b1, 8'h00, 1'b0);
    run_case(3'd2, 8'hFF, 16'h1234, 16'h0, 8'h55, 8'hFF, 1'b1, 8'h80, 1'b0);
    run_case(3'd2, 8'h40, 16'h1234, 16'h0, 8'h00, 8'h82, 1'b1, 8'h7F, 1'b0);
    // R4 and R8 masks: bits 5 and 4 kept from current status
    run_case(3'd3, 8'h20, 16'h0, 16'h0, 8'h00, 8'h00, 1'b1, 8'hFF, 1'b0);
    run_case(3'd3, 8'h21, 16'h0, 16'h0, 8'h00, 8'hFF, 1'b1, 8'h00, 1'b0);
    run_case(3'd7, 8'hFE, 16'h0, 16'h0, 8'h00, 8'h30, 1'b1, 8'hFF, 1'b0);
    // R5/R7 PC borrow and carry across bytes
    run_case(3'd4, 8'h00, 16'h2300, 16'hC0DE, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0);
    run_case(3'd6, 8'h02, 16'h12FF, 16'h0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0);
    // R10: request held high while busy is ignored
    run_case(3'd5, 8'h7F, 16'h4444, 16'h0, 8'h11, 8'h22, 1'b0, 8'h00, 1'b1);
    run_case(3'd7, 8'h01, 16'h4444, 16'h0, 8'h11, 8'h22, 1'b0, 8'h00, 1'b1);
    @(negedge clk);
    chk("R10", "idle busy after command", busy, 0);
    chk("R1", "accesses outside stack/vector", stray, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule